// File: doc/BRIEF.md
# Cascaded Two-Stage Interrupt Request Combiner

This block merges sixteen interrupt sources into one processor interrupt line, using two eight-input request units in a chain. Sources report through one event port that carries a source index and a set-or-clear flag. Each unit keeps a request register and an inhibit register. A set inhibit bit masks the matching request. Whenever any enabled request is present in the secondary unit, input 2 of the primary unit is driven. The processor line is high while the primary unit has any enabled request.

Alongside the line, the block holds the number of the lowest pending source, 0 to 15, as a 5-bit value. The scan that finds it skips the chaining input, and it runs only at specific moments. It runs when an event or an inhibit write changes the primary enabled set. It also runs when a dedicated rescan index arrives. Between those moments the value is held, even if secondary activity that the primary unit masks would give a different answer.

Top module: `pic_cascade_combiner`

## Requirements
- R1: An event with index 0..7 sets (assert flag 1) or clears (assert flag 0) primary request bit index. An event with index 8..15 does the same to secondary request bit (index - 8).
- R2: Primary input 2 is high exactly when the secondary unit has a request whose inhibit bit is 0. An event on index 2 has no effect.
- R3: The enabled set of a unit is request AND NOT inhibit. Both inhibit registers reset to 0xFF. A write with select 0 loads the primary inhibit register, and a write with select 1 loads the secondary one.
- R4: `irq_o` is high exactly when the primary enabled set is non-zero. It reflects the state in the cycle after the clock edge that captured the event or write.
- R5: The scan looks at positions 0..15, skipping 2. Positions 0..7 test primary enabled bits and 8..15 test secondary enabled bits. The result is the lowest position found, or 16 if there is none.
- R6: The pending-source value is reloaded only when the event or write changes the primary enabled set. Otherwise it holds its value, even when secondary enabled bits change.
- R7: Index 16 forces a rescan and leaves all requests unchanged. Indices 17..31 have no effect.
- R8: After reset, `irq_o` is 0 and `pend_src_o` is 16.
- R9: An event and an inhibit write in the same cycle both take effect. The change test compares the primary enabled set before that cycle with the set after both updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_valid_i | input | 1 | Event strobe |
| evt_idx_i | input | 5 | Source index; 16 requests a rescan |
| evt_assert_i | input | 1 | 1 sets the request, 0 clears it |
| inh_we_i | input | 1 | Inhibit register write strobe |
| inh_sel_i | input | 1 | 0 selects the primary unit, 1 the secondary unit |
| inh_wdata_i | input | 8 | Inhibit value; a 1 masks that input |
| irq_o | output | 1 | Processor interrupt line |
| pend_src_o | output | 5 | Latched lowest pending source, 16 if none |

## Verification
The directed patterns each separate one case:
- a primary source alone against a secondary source reached only through the chaining input;
- a source that is pending but masked against one that is enabled;
- a change in secondary activity that the primary unit masks, where the value must hold, against an explicit rescan, where it must reload;
- an event on index 2 and on out-of-range indices, which must leave both outputs unchanged;
- an inhibit write in the same cycle as an event, where the combined effect must decide the change test.

Random mixes of events, rescans and inhibit writes are then compared against a reference model built from the requirements.

// File: rtl/pic_cmb_pkg.sv
package pic_cmb_pkg;
  localparam int unsigned UNIT_W       = 8;
  localparam int unsigned NUM_SRC      = 2 * UNIT_W;
  localparam int unsigned IDX_W        = $clog2(NUM_SRC) + 1;
  localparam int unsigned SRC_W        = $clog2(NUM_SRC) + 1;
  localparam int unsigned REASSERT_IDX = NUM_SRC;
  localparam int unsigned CASC_POS     = 2;
endpackage

// File: rtl/pic_unit.sv
module pic_unit #(
  parameter int unsigned   W        = 8,
  parameter bit            CASC_EN  = 1'b0,
  parameter int unsigned   CASC_POS = 2,
  parameter logic [W-1:0]  RST_INH  = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         inh_we_i,
  input  logic [W-1:0] inh_wdata_i,
  input  logic         casc_i,
  input  logic         casc_nxt_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] en_nxt_o
);
  logic [W-1:0] req_q, req_d, inh_q, inh_d;
  logic [W-1:0] eff_q, eff_d;

  always_comb begin
    req_d = (req_q | set_i) & ~clr_i;
    inh_d = inh_we_i ? inh_wdata_i : inh_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      inh_q <= RST_INH;
    end else begin
      req_q <= req_d;
      inh_q <= inh_d;
    end
  end

  generate
    if (CASC_EN) begin : g_casc
      // chained input is driven by the lower stage, never by events
      always_comb begin
        eff_q = req_q;
        eff_d = req_d;
        eff_q[CASC_POS] = casc_i;
        eff_d[CASC_POS] = casc_nxt_i;
      end
    end else begin : g_leaf
      logic unused_casc;
      assign unused_casc = casc_i ^ casc_nxt_i;
      assign eff_q = req_q;
      assign eff_d = req_d;
    end
  endgenerate

  assign en_o     = eff_q & ~inh_q;
  assign en_nxt_o = eff_d & ~inh_d;

  // R3
  all_inh_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&inh_q) |-> (en_o == '0));

  generate
    if (CASC_EN) begin : g_casc_chk
      // R2
      casc_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_o[CASC_POS] |-> casc_i);
    end
  endgenerate
endmodule

// File: rtl/pic_prio_scan.sv
module pic_prio_scan #(
  parameter int unsigned W        = 8,
  parameter int unsigned CASC_POS = 2,
  parameter int unsigned SRC_W    = 5,
  localparam int unsigned N       = 2 * W
) (
  input  logic [W-1:0]     pri_en_i,
  input  logic [W-1:0]     sec_en_i,
  output logic [SRC_W-1:0] src_o
);
  logic [N-1:0] all_en;
  assign all_en = {sec_en_i, pri_en_i};

  always_comb begin
    src_o = SRC_W'(N);
    for (int x = N - 1; x >= 0; x--) begin
      if (x != int'(CASC_POS) && all_en[x]) src_o = SRC_W'(x);
    end
  end
endmodule

// File: rtl/pic_cascade_combiner.sv
module pic_cascade_combiner
  import pic_cmb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_valid_i,
  input  logic [IDX_W-1:0] evt_idx_i,
  input  logic             evt_assert_i,
  input  logic             inh_we_i,
  input  logic             inh_sel_i,
  input  logic [UNIT_W-1:0] inh_wdata_i,
  output logic             irq_o,
  output logic [SRC_W-1:0] pend_src_o
);
  logic [NUM_SRC-1:0] hit, set_v, clr_v;
  logic [UNIT_W-1:0]  pri_en, pri_en_nxt, sec_en, sec_en_nxt;
  logic               reassert;
  logic [SRC_W-1:0]   scan_res, pend_q;

  always_comb begin
    hit = '0;
    if (evt_valid_i && (evt_idx_i < IDX_W'(NUM_SRC)))
      hit = {{(NUM_SRC-1){1'b0}}, 1'b1} << evt_idx_i;
    set_v = evt_assert_i ? hit : '0;
    clr_v = evt_assert_i ? '0 : hit;
  end

  assign reassert = evt_valid_i && (evt_idx_i == IDX_W'(REASSERT_IDX));

  pic_unit #(.W(UNIT_W), .CASC_EN(1'b0), .CASC_POS(CASC_POS)) u_sec (
    .clk_i, .rst_ni,
    .set_i       (set_v[NUM_SRC-1:UNIT_W]),
    .clr_i       (clr_v[NUM_SRC-1:UNIT_W]),
    .inh_we_i    (inh_we_i && inh_sel_i),
    .inh_wdata_i (inh_wdata_i),
    .casc_i      (1'b0),
    .casc_nxt_i  (1'b0),
    .en_o        (sec_en),
    .en_nxt_o    (sec_en_nxt)
  );

  pic_unit #(.W(UNIT_W), .CASC_EN(1'b1), .CASC_POS(CASC_POS)) u_pri (
    .clk_i, .rst_ni,
    .set_i       (set_v[UNIT_W-1:0]),
    .clr_i       (clr_v[UNIT_W-1:0]),
    .inh_we_i    (inh_we_i && !inh_sel_i),
    .inh_wdata_i (inh_wdata_i),
    .casc_i      (|sec_en),
    .casc_nxt_i  (|sec_en_nxt),
    .en_o        (pri_en),
    .en_nxt_o    (pri_en_nxt)
  );

  pic_prio_scan #(.W(UNIT_W), .CASC_POS(CASC_POS), .SRC_W(SRC_W)) u_scan (
    .pri_en_i (pri_en_nxt),
    .sec_en_i (sec_en_nxt),
    .src_o    (scan_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 pend_q <= SRC_W'(NUM_SRC);
    else if ((pri_en_nxt != pri_en) || reassert) pend_q <= scan_res;
  end

  assign irq_o      = |pri_en;
  assign pend_src_o = pend_q;

  // R5
  pend_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q <= SRC_W'(NUM_SRC)) && (pend_q != SRC_W'(CASC_POS)));

  // R6
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pend_q) |-> $past(evt_valid_i || inh_we_i));

  // R4
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(evt_valid_i || inh_we_i));
endmodule

// File: tb/pic_cascade_combiner_bench.sv
module pic_cascade_combiner_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       evt_valid_i = 1'b0, evt_assert_i = 1'b0;
  logic [4:0] evt_idx_i = '0;
  logic       inh_we_i = 1'b0, inh_sel_i = 1'b0;
  logic [7:0] inh_wdata_i = '0;
  logic       irq_o;
  logic [4:0] pend_src_o;

  int checks = 0, errors = 0;
  logic [5:0] exp_q[$];
  string      tag_q[$];

  logic [7:0] m_pr = 0, m_sr = 0, m_pi = 8'hFF, m_si = 8'hFF;
  logic [4:0] m_pend = 5'd16;

  always #5 clk = ~clk;

  pic_cascade_combiner u_pic_cascade_combiner (
    .clk_i(clk), .rst_ni, .evt_valid_i, .evt_idx_i, .evt_assert_i,
    .inh_we_i, .inh_sel_i, .inh_wdata_i, .irq_o, .pend_src_o);

  function automatic logic [7:0] prim_en(logic [7:0] pr, logic [7:0] sr,
                                         logic [7:0] pi, logic [7:0] si);
    logic [7:0] v = pr;
    v[2] = (sr & ~si) != 0;
    return v & ~pi;
  endfunction

  function automatic logic [4:0] lowest(logic [15:0] en);
    for (int k = 0; k < 16; k++)
      if (k != 2 && en[k]) return 5'(k);
    return 5'd16;
  endfunction

  task automatic do_op(bit ev, bit asr, int idx, bit we, bit sel,
                       logic [7:0] wd, string tag);
    logic [7:0] npr, nsr, npi, nsi, old_pe, new_pe;
    @(negedge clk);
    evt_valid_i = ev; evt_assert_i = asr; evt_idx_i = 5'(idx);
    inh_we_i = we; inh_sel_i = sel; inh_wdata_i = wd;
    npr = m_pr; nsr = m_sr; npi = m_pi; nsi = m_si;
    if (ev && idx < 8 && idx != 2) npr[idx] = asr;
    if (ev && idx >= 8 && idx < 16) nsr[idx-8] = asr;
    if (we && !sel) npi = wd;
    if (we && sel) nsi = wd;
    old_pe = prim_en(m_pr, m_sr, m_pi, m_si);
    new_pe = prim_en(npr, nsr, npi, nsi);
    if (old_pe != new_pe || (ev && idx == 16))
      m_pend = lowest({nsr & ~nsi, new_pe});
    m_pr = npr; m_sr = nsr; m_pi = npi; m_si = nsi;
    @(posedge clk);
    exp_q.push_back({new_pe != 0, m_pend});
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    logic [5:0] e;
    string t;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({irq_o, pend_src_o} !== e) begin
          errors++;
          $display("FAIL %s: got irq=%0b src=%0d, expected irq=%0b src=%0d",
                   t, irq_o, pend_src_o, e[5], e[4:0]);
        end
      end
    end
  end

  initial begin : watchdog
    #500us;
    checks++; errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    checks++;
    if (irq_o !== 1'b0 || pend_src_o !== 5'd16) begin
      errors++;
      $display("FAIL R8 reset: got irq=%0b src=%0d, expected irq=0 src=16", irq_o, pend_src_o);
    end
    do_op(1, 1, 5, 0, 0, 8'h00, "R3 masked request quiet");
    do_op(0, 0, 0, 1, 0, 8'h00, "R3 R4 primary unmask");
    do_op(1, 1, 1, 0, 0, 8'h00, "R1 R5 lower primary");
    do_op(1, 1, 12, 0, 0, 8'h00, "R3 secondary masked");
    do_op(0, 0, 0, 1, 1, 8'h00, "R2 secondary unmask raises input 2");
    do_op(1, 0, 1, 0, 0, 8'h00, "R1 clear primary");
    do_op(1, 0, 5, 0, 0, 8'h00, "R2 R5 secondary via chain");
    do_op(1, 1, 2, 0, 0, 8'h00, "R2 index 2 ignored");
    do_op(1, 1, 9, 0, 0, 8'h00, "R6 hold on secondary change");
    do_op(1, 1, 16, 0, 0, 8'h00, "R7 rescan");
    do_op(1, 1, 20, 0, 0, 8'h00, "R7 out of range ignored");
    do_op(1, 0, 12, 0, 0, 8'h00, "R6 hold");
    do_op(1, 0, 9, 0, 0, 8'h00, "R4 R5 all clear");
    do_op(1, 1, 8, 0, 0, 8'h00, "R5 source 8");
    do_op(0, 0, 0, 1, 0, 8'h04, "R3 chain input inhibited");
    do_op(1, 1, 3, 1, 0, 8'h00, "R9 event with inhibit write");
    do_op(1, 1, 0, 1, 1, 8'hFF, "R9 event with secondary write");
    for (int i = 0; i < 300; i++) begin
      int  ix  = $urandom_range(0, 20);
      bit  w   = ($urandom_range(0, 3) == 0);
      do_op($urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1, ix, w,
            $urandom_range(0, 1) == 1, 8'($urandom_range(0, 255)),
            "R1 R5 R6 random");
    end
    do_op(0, 0, 0, 0, 0, 8'h00, "R6 idle hold");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule